// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the serial front end of a byte-wide nonvolatile array of 4096 bytes. A host drives it as an SPI slave in clock mode 0 or mode 3. An active-low select, the serial clock and the serial data input are oversampled by the system clock. Edges are found by comparing successive samples. The block decodes an 8-bit opcode and then, depending on the opcode, shifts in a 16-bit address and data bytes or shifts out memory or status bytes, most significant bit first. The serial output has a separate drive enable, so the pad can go to high impedance.

Array writes are collected in a 32-byte page buffer. They reach the array only when the select rises exactly on a byte boundary after at least one data byte. A down-counter then stands in for the self-timed nonvolatile programming time and drives the write-in-progress flag. While that flag is set, only the status read is accepted. The surrounding protection block decides whether an array or status write may proceed, through two lock inputs. It receives back the three stored protection bits.

The controller is a single state machine. Its states are IDLE (waiting for a select fall), OPCODE, ADDR, RDATA (sequential read), WDATA (page data), SRIN (status byte in), SRHOLD (status byte complete, waiting for deselect), SROUT (status stream), WENHOLD (enable opcode complete, waiting for deselect) and SINK (ignore until deselect). The transitions are:
- IDLE to OPCODE on a select fall.
- OPCODE, after 8 bits, to WENHOLD, SROUT, SRIN, ADDR or SINK by opcode.
- ADDR, after 16 bits, to RDATA or WDATA.
- SRIN, after 8 bits, to SRHOLD.
- WENHOLD and SRHOLD to SINK on any further clock.
- Every state to IDLE on a select rise.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset, so_oe is 0, prot_cfg is 0, wip is 0 and a status read returns 0x30.
- R2: A select that is already low when reset ends is ignored; instructions are accepted only after a high-to-low transition of cs_n.
- R3: Bits are captured on rising SCK and SO changes after falling SCK, in both mode 0 (SCK idle low) and mode 3 (SCK idle high); so_oe is 0 whenever cs_n is high and 1 during read data.
- R4: READ (0x03), followed by a 16-bit address of which the low 12 bits are used, streams bytes from consecutive addresses, wrapping from 0xFFF to 0x000.
- R5: WRITE (0x02) data bytes go to consecutive offsets within the 32-byte page of the start address, wrapping from offset 31 to offset 0 and overwriting earlier bytes.
- R6: A write commits only when cs_n rises after bit 0 of a data byte with at least one byte received; a rise mid-byte or right after the address leaves memory and wip unchanged.
- R7: WREN (0x06) sets the enable latch only if cs_n rises right after its 8 bits; WRITE and WRSR (0x01) with the latch clear are ignored.
- R8: WRDI (0x04) clears the enable latch, and the latch clears when a write cycle ends.
- R9: A committed write holds wip at 1 for WC_CYCLES clocks; RDSR (0x05) works during that time and shows bit 0 set, and every other instruction is ignored.
- R10: SFLB (0x00) sets the flag bit and 0x04 clears it; the status byte is {bit7 wpen, bit6 flag, bits5:4 = 11, bit3 bl1, bit2 bl0, bit1 enable latch, bit0 wip}.
- R11: A committed WRSR stores data bits 7, 3 and 2 into prot_cfg as {wpen, bl1, bl0}.
- R12: arr_lock high at the committing select rise drops an array write, and sr_lock does the same for a status write: no wip, no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| arr_lock | input | 1 | Protection decision: refuse the pending array write |
| sr_lock | input | 1 | Protection decision: refuse the pending status write |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so |
| wip | output | 1 | Write cycle in progress |
| prot_cfg | output | 3 | Stored {wpen, bl1, bl0} |

## Verification
A wrong state shows up at the ports. A wrong enable latch or flag appears in the next status read. A misplaced page offset or a bad read pointer appears in the first byte read back from the affected address. A commit that fires at the wrong select rise shows as wip being set, or left clear, in the status read that immediately follows the deselect. Instruction gating during the busy window is seen within one byte time, because so_oe fails to assert.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_SFLB  = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_RDATA, ST_WDATA,
        ST_SRIN, ST_SRHOLD, ST_SROUT, ST_WENHOLD, ST_SINK
    } ee_state_t;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_act,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [STAGES:0]   cs_q;
    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] si_q;

    // select resets to "low" so a select held low through reset yields no fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            sck_q <= '0;
            si_q  <= '0;
        end else begin
            cs_q  <= {cs_q[STAGES-1:0], cs_n};
            sck_q <= {sck_q[STAGES-1:0], sck};
            si_q  <= {si_q[STAGES-2:0], si};
        end
    end

    assign cs_act   = !cs_q[STAGES-1];
    assign cs_fall  =  cs_q[STAGES] && !cs_q[STAGES-1];
    assign cs_rise  = !cs_q[STAGES] &&  cs_q[STAGES-1];
    assign sck_rise = !sck_q[STAGES] &&  sck_q[STAGES-1];
    assign sck_fall =  sck_q[STAGES] && !sck_q[STAGES-1];
    assign si_s     = si_q[STAGES-1];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     page_load,
    input  logic [ADDR_W-PAGE_W-1:0] page_addr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     commit,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0]               mem  [DEPTH];
    logic [7:0]               pbuf [PAGE];
    logic [PAGE-1:0]          pmask;
    logic [ADDR_W-PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask  <= '0;
            page_q <= '0;
        end else if (page_load) begin
            pmask  <= '0;
            page_q <= page_addr;
        end else if (buf_we) begin
            pmask[buf_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_din;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE; i++) begin
            if (commit && pmask[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
        end
    end

    assign rd_data = mem[rd_addr];

    // R6
    commit_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (pmask != '0));
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WC_CYCLES = 2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_act,
    input  logic                     cs_fall,
    input  logic                     cs_rise,
    input  logic                     sck_rise,
    input  logic                     sck_fall,
    input  logic                     si_s,
    input  logic                     arr_lock,
    input  logic                     sr_lock,
    input  logic [7:0]               rd_data,
    output logic                     page_load,
    output logic [ADDR_W-PAGE_W-1:0] page_addr,
    output logic                     buf_we,
    output logic [PAGE_W-1:0]        buf_idx,
    output logic [7:0]               buf_din,
    output logic                     commit,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     so,
    output logic                     so_oe,
    output logic [2:0]               prot_cfg,
    output logic                     wip
);
    localparam int CNT_W = $clog2(WC_CYCLES + 1);

    ee_state_t         state, nxt;
    logic [4:0]        bitcnt;
    logic [ADDR_W-1:0] shreg, addr, addr_full;
    logic [7:0]        byte_in, txsh, stat;
    logic [2:0]        ocnt, cfg;
    logic [CNT_W-1:0]  busy_cnt;
    logic              is_wr, got_byte, wel, flag;
    logic              ev_bit, byte_done, addr_done, dec_ok, sr_commit, out_st;

    assign ev_bit    = cs_act && sck_rise;
    assign byte_done = ev_bit && (bitcnt[2:0] == 3'd7);
    assign byte_in   = {shreg[6:0], si_s};
    assign addr_full = {shreg[ADDR_W-2:0], si_s};
    assign addr_done = (state == ST_ADDR) && ev_bit && (bitcnt == 5'd15);
    assign dec_ok    = !wip || (byte_in == OP_RDSR);
    assign wip       = (busy_cnt != '0);
    assign stat      = {cfg[2], flag, 2'b11, cfg[1:0], wel, wip};
    assign out_st    = (state == ST_RDATA) || (state == ST_SROUT);

    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) nxt = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    if (!dec_ok) nxt = ST_SINK;
                    else case (byte_in)
                        OP_WREN:  nxt = ST_WENHOLD;
                        OP_RDSR:  nxt = ST_SROUT;
                        OP_WRSR:  nxt = wel ? ST_SRIN : ST_SINK;
                        OP_READ:  nxt = ST_ADDR;
                        OP_WRITE: nxt = wel ? ST_ADDR : ST_SINK;
                        default:  nxt = ST_SINK;
                    endcase
                end
                ST_ADDR:    if (addr_done) nxt = is_wr ? ST_WDATA : ST_RDATA;
                ST_SRIN:    if (byte_done) nxt = ST_SRHOLD;
                ST_WENHOLD: if (ev_bit) nxt = ST_SINK;
                ST_SRHOLD:  if (ev_bit) nxt = ST_SINK;
                ST_RDATA, ST_WDATA, ST_SROUT, ST_SINK: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign page_load = addr_done && is_wr;
    assign page_addr = addr_full[ADDR_W-1:PAGE_W];
    assign buf_we    = (state == ST_WDATA) && byte_done;
    assign buf_idx   = addr[PAGE_W-1:0];
    assign buf_din   = byte_in;
    assign rd_addr   = addr;
    assign commit    = cs_rise && (state == ST_WDATA) && got_byte &&
                       (bitcnt[2:0] == 3'd0) && !arr_lock;
    assign sr_commit = cs_rise && (state == ST_SRHOLD) && !sr_lock;
    assign so        = txsh[7];
    assign so_oe     = cs_act && out_st;
    assign prot_cfg  = cfg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0; shreg <= '0; addr <= '0; is_wr <= 1'b0;
            got_byte <= 1'b0; wel <= 1'b0; flag <= 1'b0; cfg <= '0;
            busy_cnt <= '0; txsh <= '0; ocnt <= '0;
        end else begin
            if (cs_fall) begin
                bitcnt   <= '0;
                got_byte <= 1'b0;
                ocnt     <= '0;
            end else if (ev_bit) begin
                shreg <= addr_full;
                if ((state == ST_OPCODE && bitcnt == 5'd7) || addr_done) bitcnt <= '0;
                else bitcnt <= bitcnt + 5'd1;
            end
            if (state == ST_OPCODE && byte_done) begin
                is_wr <= (byte_in == OP_WRITE);
                if (dec_ok) begin
                    case (byte_in)
                        OP_WRDI: begin wel <= 1'b0; flag <= 1'b0; end
                        OP_SFLB: flag <= 1'b1;
                        default: ;
                    endcase
                end
            end
            if (addr_done) addr <= addr_full;
            if (buf_we) begin
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                got_byte <= 1'b1;
            end
            if (cs_act && sck_fall && out_st) begin
                if (ocnt == 3'd0) begin
                    txsh <= (state == ST_RDATA) ? rd_data : stat;
                    if (state == ST_RDATA) addr <= addr + 1'b1;
                end else begin
                    txsh <= {txsh[6:0], 1'b0};
                end
                ocnt <= ocnt + 3'd1;
            end
            if (cs_rise && state == ST_WENHOLD) wel <= 1'b1;
            if (sr_commit) cfg <= {shreg[7], shreg[3:2]};
            if (commit || sr_commit) begin
                busy_cnt <= CNT_W'(WC_CYCLES);
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == CNT_W'(1)) wel <= 1'b0;
            end
        end
    end

    // R3
    so_off_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !so_oe);
    // R9
    wip_from_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise));
    // R8
    wel_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wip) && wip) |-> ($stable(wel) && $stable(flag) && $stable(cfg)));
    // R7
    wel_set_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise));
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave #(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WC_CYCLES = 2000,
    parameter int SYNC_STG  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       arr_lock,
    input  logic       sr_lock,
    output logic       so,
    output logic       so_oe,
    output logic       wip,
    output logic [2:0] prot_cfg
);
    logic                     cs_act, cs_fall, cs_rise, sck_rise, sck_fall, si_s;
    logic                     page_load, buf_we, commit;
    logic [ADDR_W-PAGE_W-1:0] page_addr;
    logic [PAGE_W-1:0]        buf_idx;
    logic [7:0]               buf_din, rd_data;
    logic [ADDR_W-1:0]        rd_addr;

    spi_ee_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WC_CYCLES(WC_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
        .arr_lock(arr_lock), .sr_lock(sr_lock), .rd_data(rd_data),
        .page_load(page_load), .page_addr(page_addr), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_din(buf_din), .commit(commit), .rd_addr(rd_addr),
        .so(so), .so_oe(so_oe), .prot_cfg(prot_cfg), .wip(wip)
    );

    spi_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .page_load(page_load), .page_addr(page_addr),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din), .commit(commit),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/spi_ee_slave_test.sv
module spi_ee_slave_test;
    localparam int WC = 300;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, arr_lock = 1'b0, sr_lock = 1'b0;
    logic so, so_oe, wip;
    logic [2:0] prot_cfg;
    bit mode3 = 1'b0;
    int n_chk = 0, n_err = 0;
    logic [7:0] mm [4096];
    bit         kn [4096];
    logic [7:0] wd [40];
    logic [7:0] rb [16];

    spi_ee_slave #(.WC_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .arr_lock(arr_lock), .sr_lock(sr_lock), .so(so), .so_oe(so_oe),
        .wip(wip), .prot_cfg(prot_cfg)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] page_loc(input logic [11:0] a, input int k);
        return {a[11:5], 5'(int'(a[4:0]) + k)};
    endfunction

    task automatic sel();
        sck = mode3; #100; cs_n = 1'b0; #200;
    endtask

    task automatic desel();
        #200; cs_n = 1'b1; #200;
    endtask

    task automatic xfer(input logic [7:0] d, input int nb, output logic [7:0] q);
        q = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (mode3) begin
                sck = 1'b0; si = d[i]; #100; q[i] = so; sck = 1'b1; #100;
            end else begin
                si = d[i]; #100; q[i] = so; sck = 1'b1; #100; sck = 1'b0;
            end
        end
    endtask

    task automatic xb(input logic [7:0] d);
        logic [7:0] q;
        xfer(d, 8, q);
    endtask

    task automatic cmd(input logic [7:0] op);
        sel(); xb(op); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        sel(); xb(8'h05); xfer(8'h00, 8, s); desel();
    endtask

    task automatic wait_wc();
        repeat (WC + 20) @(posedge clk);
        #10;
    endtask

    task automatic wr(input logic [11:0] a, input int n, input bit upd);
        sel(); xb(8'h02); xb({4'h0, a[11:8]}); xb(a[7:0]);
        for (int k = 0; k < n; k++) begin
            xb(wd[k]);
            if (upd) begin mm[page_loc(a, k)] = wd[k]; kn[page_loc(a, k)] = 1'b1; end
        end
        desel();
    endtask

    task automatic rd(input logic [11:0] a, input int n);
        logic [7:0] q;
        sel(); xb(8'h03); xb({4'h0, a[11:8]}); xb(a[7:0]);
        for (int k = 0; k < n; k++) begin xfer(8'h00, 8, q); rb[k] = q; end
        desel();
    endtask

    task automatic rd_cmp(input string tag, input logic [11:0] a, input int n);
        rd(a, n);
        for (int k = 0; k < n; k++)
            if (kn[12'(a + k)]) chk(tag, rb[k], mm[12'(a + k)]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] s, q;
        logic [11:0] a;
        int n;
        void'($urandom(32'h1d5e_ed01));
        for (int i = 0; i < 4096; i++) kn[i] = 1'b0;
        #200 rst_n = 1'b1;
        #100;
        // R1 reset state
        chk("R1 so_oe", so_oe, 0);
        chk("R1 prot_cfg", prot_cfg, 0);
        chk("R1 wip", wip, 0);
        // R2 select low through reset: WREN must be ignored
        xb(8'h06); desel();
        rdsr(s); chk("R1 R2 status", s, 8'h30);
        chk("R3 so_oe deselected", so_oe, 0);
        // R10 flag
        cmd(8'h00); rdsr(s); chk("R10 flag set", s, 8'h70);
        cmd(8'h04); rdsr(s); chk("R10 flag clear", s, 8'h30);
        // R7 WREN with trailing bits, write without latch
        sel(); xb(8'h06); xb(8'h00); desel();
        rdsr(s); chk("R7 late deselect", s, 8'h30);
        wd[0] = 8'h5A; wr(12'h100, 1, 0);
        rdsr(s); chk("R7 write without latch", s, 8'h30);
        cmd(8'h06); rdsr(s); chk("R7 latch set", s, 8'h32);
        cmd(8'h04); rdsr(s); chk("R8 latch cleared", s, 8'h30);
        // R4 R5 directed fills
        for (int k = 0; k < 32; k++) wd[k] = 8'(k * 3 + 1);
        cmd(8'h06); wr(12'h000, 32, 1);
        rdsr(s); chk("R9 status busy", s, 8'h33);
        chk("R9 wip pin", wip, 1);
        sel(); xb(8'h03); xb(8'h00); xb(8'h00); #100;
        chk("R9 read ignored while busy", so_oe, 0); desel();
        wait_wc();
        rdsr(s); chk("R8 R9 cycle end", s, 8'h30);
        for (int k = 0; k < 32; k++) wd[k] = ~8'(k);
        cmd(8'h06); wr(12'hFE0, 32, 1); wait_wc();
        sel(); xb(8'h03); xb(8'h0F); xb(8'hFE); #100;
        chk("R3 so_oe reading", so_oe, 1);
        xfer(8'h00, 8, q); chk("R4 byte 0xFFE", q, mm[12'hFFE]);
        xfer(8'h00, 8, q); chk("R4 byte 0xFFF", q, mm[12'hFFF]);
        xfer(8'h00, 8, q); chk("R4 wrap 0x000", q, mm[12'h000]);
        desel();
        chk("R3 so_oe after read", so_oe, 0);
        wd[0] = 8'hA0; wd[1] = 8'hA1; wd[2] = 8'hA2; wd[3] = 8'hA3;
        cmd(8'h06); wr(12'h05E, 4, 1); wait_wc();
        rd(12'h040, 2); chk("R5 page wrap off0", rb[0], 8'hA2); chk("R5 page wrap off1", rb[1], 8'hA3);
        rd(12'h05E, 2); chk("R5 page start", rb[0], 8'hA0);
        // R6 aborts
        cmd(8'h06);
        sel(); xb(8'h02); xb(8'h00); xb(8'h10); xb(8'hC3); xfer(8'hFF, 3, q); desel();
        rdsr(s); chk("R6 mid-byte abort", s, 8'h32);
        sel(); xb(8'h02); xb(8'h00); xb(8'h10); desel();
        rdsr(s); chk("R6 no data abort", s, 8'h32);
        rd(12'h010, 1); chk("R6 memory kept", rb[0], mm[12'h010]);
        // R12 array lock
        arr_lock = 1'b1; wd[0] = 8'hEE; wr(12'h011, 1, 0); arr_lock = 1'b0;
        rdsr(s); chk("R12 array lock", s, 8'h32);
        rd(12'h011, 1); chk("R12 memory kept", rb[0], mm[12'h011]);
        // R11 status write, R12 status lock
        sel(); xb(8'h01); xb(8'h8C); desel();
        chk("R11 prot_cfg", prot_cfg, 3'b111);
        rdsr(s); chk("R11 status busy", s, 8'hBF);
        wait_wc(); rdsr(s); chk("R11 status stored", s, 8'hBC);
        cmd(8'h06); sr_lock = 1'b1; sel(); xb(8'h01); xb(8'h00); desel(); sr_lock = 1'b0;
        chk("R12 status lock", prot_cfg, 3'b111);
        sel(); xb(8'h01); xb(8'h00); desel(); wait_wc();
        chk("R11 prot_cfg cleared", prot_cfg, 3'b000);
        // random page writes and reads in both modes
        for (int it = 0; it < 16; it++) begin
            mode3 = bit'($urandom % 2);
            a = 12'($urandom);
            n = 1 + int'($urandom % 36);
            for (int k = 0; k < n; k++) wd[k] = 8'($urandom);
            cmd(8'h06); wr(a, n, 1); wait_wc();
            rdsr(s); chk("R8 random end status", s, 8'h30);
            rd_cmp(mode3 ? "R3 R4 R5 mode3 readback" : "R4 R5 mode0 readback",
                   {a[11:5], 5'h00}, 1 + int'($urandom % 12));
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule